// File: doc/BRIEF.md
# One-Time-Enable Watchdog Timer

This block supervises software with a free-running timeout. Software writes one byte-wide, write-only control register. That byte sets the division ratio, arms the watchdog and restarts the count. After the watchdog has been armed, it stays armed: no write can disarm it, and only a power-on reset returns it to the idle state. The control register also keeps its contents through the general reset. A chip that the watchdog itself has restarted therefore comes back with the same timeout already running.

The count clock is built from three stages. The system clock first passes through a fixed divider, twelve by default. A selectable power-of-two prescaler then divides it by 2 to 256. Each prescaler period advances a 15-bit counter. When that counter wraps past its all-ones value, the block issues a one-cycle reset request to the chip's reset logic. Software prevents this by writing the clear bit often enough. Setting the `BASE_DIV` parameter to 1 removes the fixed divider, and the `CNT_W` parameter sets the counter width.

Top module: `owdt_top`

## Requirements
- R1: When `por_n` is low, the control register becomes 0x00, the watchdog is disarmed and `rst_req` is 0. While the watchdog is disarmed, `rst_req` stays 0 whatever is written, including writes of the clear bit and of prescaler values.
- R2: Bit 5 of a written byte arms the watchdog. A later write with bit 5 at 0 leaves it armed, and the count continues.
- R3: The active-high `rst` input restarts the fixed divider, the prescaler and the counter from zero at the edge where it is sampled. It leaves the control register unchanged, so the armed state and the prescaler select survive it.
- R4: A write with bit 4 set restarts the fixed divider, the prescaler and the counter from zero at the accepting edge. The stored copy of bit 4 is always 0.
- R5: Bits 2:0 of the register, as a value s, divide the fixed-divider output by 2^(s+1), which covers 2 to 256.
- R6: Let E be the edge that accepts the arming or clearing write, or that samples `rst`. If nothing else restarts the count, `rst_req` is 1 in the cycle after edge E + BASE_DIV·2^(s+1)·2^CNT_W and is 0 in every cycle before that.
- R7: After a request, the counter wraps to zero and keeps counting. Without a clear, the next request follows one full period later.
- R8: `rst_req` is a registered pulse exactly one clock cycle wide.
- R9: A prescaler select that is written without the clear bit while the watchdog runs takes effect at the next prescaler terminal count. The prescaler period already in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| rst | input | 1 | General reset, active high, synchronous; restarts the count, keeps the register |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Byte to write: bit 5 arm, bit 4 clear, bits 2:0 prescaler select |
| rst_req | output | 1 | One-cycle device reset request on counter overflow |

## Verification
The bench builds the block with a 4-bit counter and a fixed divider of 3. A full timeout then lasts between 96 and 12288 clocks, so every prescaler ratio at both ends of the range can be run to overflow. The same settings bring the wrap and second request, a prescaler change in the middle of a period, and the restart after a general reset into a short run. Every request pulse is scheduled in advance, and a pulse that arrives early or was not expected counts as a failure.

// File: rtl/owdt_pkg.sv
package owdt_pkg;
  localparam int CTRL_W  = 8;
  localparam int ARM_BIT = 5;
  localparam int CLR_BIT = 4;
  localparam int SEL_W   = 3;
endpackage

// File: rtl/owdt_ctrl.sv
module owdt_ctrl
  import owdt_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [SEL_W-1:0]  sel_nxt,
  output logic              clr
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d          = wr_data;
    ctrl_d[CLR_BIT] = 1'b0;
    ctrl_d[ARM_BIT] = wr_data[ARM_BIT] | ctrl_q[ARM_BIT];
  end

  // only power-on reset touches the register
  always_ff @(posedge clk) begin
    if (!por_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign sel_nxt = wr_en ? wr_data[SEL_W-1:0] : ctrl_q[SEL_W-1:0];
  assign clr     = wr_en & wr_data[CLR_BIT];
endmodule

// File: rtl/owdt_tick.sv
module owdt_tick
  import owdt_pkg::*;
#(
  parameter int BASE_DIV = 12
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_nxt,
  output logic             tick
);
  localparam int PRE_W = 1 << SEL_W;

  logic             base_tick;
  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] act_sel;
  logic             pre_end;

  generate
    if (BASE_DIV > 1) begin : g_base
      localparam int BW = $clog2(BASE_DIV);
      logic [BW-1:0] base_q;
      assign base_tick = run && (base_q == BW'(BASE_DIV - 1));
      always_ff @(posedge clk) begin
        if (restart || !run) base_q <= '0;
        else if (base_tick)  base_q <= '0;
        else                 base_q <= base_q + 1'b1;
      end
    end else begin : g_nobase
      assign base_tick = run;
    end
  endgenerate

  function automatic logic [PRE_W-1:0] last_of(input logic [SEL_W-1:0] s);
    logic [SEL_W:0] sh;
    logic [PRE_W:0] t;
    sh = {1'b0, s} + {{SEL_W{1'b0}}, 1'b1};
    t  = ({{PRE_W{1'b0}}, 1'b1} << sh) - {{PRE_W{1'b0}}, 1'b1};
    return t[PRE_W-1:0];
  endfunction

  assign pre_end = base_tick && (pre_q == last_of(act_sel));
  assign tick    = pre_end;

  always_ff @(posedge clk) begin
    if (restart || !run) begin
      pre_q   <= '0;
      act_sel <= sel_nxt;
    end else if (pre_end) begin
      pre_q   <= '0;
      act_sel <= sel_nxt;
    end else if (base_tick) begin
      pre_q   <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/owdt_count.sv
module owdt_count #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
      req_q <= (cnt_q == TOP);
    end else begin
      req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/owdt_top.sv
module owdt_top
  import owdt_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int BASE_DIV = 12
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       rst_req
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [SEL_W-1:0]  sel_nxt;
  logic              clr;
  logic              restart;
  logic              tick;
  logic [CNT_W-1:0]  cnt_q;

  owdt_ctrl u_ctrl (
    .clk    (clk),
    .por_n  (por_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q),
    .sel_nxt(sel_nxt),
    .clr    (clr)
  );

  assign restart = !por_n || rst || clr;

  owdt_tick #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk    (clk),
    .restart(restart),
    .run    (ctrl_q[ARM_BIT]),
    .sel_nxt(sel_nxt),
    .tick   (tick)
  );

  owdt_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .restart(restart),
    .tick   (tick),
    .cnt_q  (cnt_q),
    .req_q  (rst_req)
  );
endmodule

// File: rtl/owdt_chk.sv
module owdt_chk
  import owdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              rst_req
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!por_n) !ctrl_q[ARM_BIT] |=> !rst_req); // R1
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!por_n) ctrl_q[ARM_BIT] |=> ctrl_q[ARM_BIT]); // R2
  AST_REG_KEPT: assert property (@(posedge clk) disable iff (!por_n) (rst && !wr_en) |=> $stable(ctrl_q)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!por_n) (wr_en && wr_data[CLR_BIT]) |=> (cnt_q == '0 && !ctrl_q[CLR_BIT])); // R4
  AST_REQ_WRAP: assert property (@(posedge clk) disable iff (!por_n || rst) rst_req |-> (cnt_q == '0 && $past(cnt_q) == {CNT_W{1'b1}})); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!por_n) rst_req |=> !rst_req); // R8
endmodule

bind owdt_top owdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .por_n  (por_n),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .ctrl_q (ctrl_q),
  .cnt_q  (cnt_q),
  .rst_req(rst_req)
);

// File: tb/sim_owdt_top.sv
`timescale 1ns/1ps
module sim_owdt_top;
  localparam int CW = 4;
  localparam int BD = 3;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req;

  always #2.5 clk = ~clk;

  owdt_top #(.CNT_W(CW), .BASE_DIV(BD)) u0 (
    .clk(clk), .por_n(por_n), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  val;
    string req;
  } exp_t;
  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // monitor: pops scheduled items, flags unscheduled requests
  always @(negedge clk) begin
    bit   hit;
    exp_t e;
    hit = 1'b0;
    while (q.size() > 0 && q[0].at == cyc) begin
      e = q.pop_front();
      total++;
      if (e.val === 1'b1) hit = 1'b1;
      if (rst_req !== e.val) begin
        bad++;
        $display("FAIL %s cyc=%0d rst_req actual=%b expected=%b", e.req, cyc, rst_req, e.val);
      end
    end
    if (por_n && rst_req === 1'b1 && !hit) begin
      total++;
      bad++;
      $display("FAIL R6 unscheduled request cyc=%0d actual=1 expected=0", cyc);
    end
  end

  function automatic int period(input int s);
    return BD * (2 << s) * (1 << CW);
  endfunction

  task automatic push(input int at, input logic val, input string req);
    exp_t e;
    e.at = at; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] d, output int base);
    wr_en = 1'b1;
    wr_data = d;
    base = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_ovf(input int base, input int s, input string req);
    push(base + period(s) - 1, 1'b0, req);
    push(base + period(s), 1'b1, req);
    push(base + period(s) + 1, 1'b0, "R8");
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 1; k <= n; k++) push(cyc + k * 50, 1'b0, req);
    drain();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired cyc=%0d actual=running expected=finished", cyc);
      finish_up();
    end
  end

  initial begin
    int b;
    int b2;
    int at;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    push(cyc + 1, 1'b0, "R1");
    @(negedge clk);

    // R1: unarmed writes never produce a request
    wr(8'h17, b);
    wr(8'h03, b);
    quiet(20, "R1");

    // R6 / R5: arm with select 0, then the wrap repeats (R7)
    wr(8'h20, b);
    expect_ovf(b, 0, "R6");
    push(b + 2 * period(0) - 1, 1'b0, "R7");
    push(b + 2 * period(0), 1'b1, "R7");
    drain();

    // R4: periodic clears hold off the request
    for (int k = 0; k < 5; k++) begin
      wr(8'h30, b);
      push(b + 59, 1'b0, "R4");
      repeat (60) @(negedge clk);
    end
    wr(8'h30, b);
    expect_ovf(b, 0, "R4");
    drain();

    // R2: a write with the arm bit at 0 does not disarm
    wr(8'h10, b);
    expect_ovf(b, 0, "R2");
    drain();

    // R5: middle and top prescaler ratios
    wr(8'h33, b);
    expect_ovf(b, 3, "R5");
    drain();
    wr(8'h37, b);
    expect_ovf(b, 7, "R5");
    drain();

    // R3: general reset restarts the count, select 2 survives
    wr(8'h32, b);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    b = cyc + 1;
    @(negedge clk);
    rst = 1'b0;
    expect_ovf(b, 2, "R3");
    drain();

    // R9: select change without clear lands at next prescaler terminal
    wr(8'h30, b);
    wr(8'h01, b2);
    at = b + BD * 2 + BD * 4 * ((1 << CW) - 1);
    push(at - 1, 1'b0, "R9");
    push(at, 1'b1, "R9");
    push(at + 1, 1'b0, "R8");
    drain();

    // R1: power-on reset disarms and zeroes the register
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    quiet(10, "R1");
    wr(8'h20, b);
    expect_ovf(b, 0, "R1");
    drain();

    done = 1'b1;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule